// File: doc/BRIEF.md
# Secure-Boot Selector Decoder

This block reads the four-byte security record from a one-time-programmable memory and turns the 16-bit crypto-selector field it holds into a decoded index. A single start pulse makes the block issue one read request for the aligned 32-bit word that holds the record. It then waits for the memory's ready strobe. In the cycle after the word arrives, the block raises a one-cycle done pulse. In that same cycle it presents the results: the decoded index, a margin constant chosen by that index, a secure-boot enable flag, and the two identifier bytes of the record, which pass through unchanged.

The selector carries its own redundancy. The low byte is a form byte that must be mirror-symmetric and may hold at most one zero in its lower half. The high byte is an index byte whose two nibbles must be bitwise complements. Any selector that breaks these rules decodes to the invalid index 0xFFFF. Only two index values are accepted as secure-boot selections. An unprogrammed selector (all ones) leaves secure boot off and is not treated as a fault.

Top module: `secboot_sel_decoder`

## Requirements
- R1: A start pulse while idle makes rd_req rise on the next clock with rd_addr equal to byte address 0x1580. rd_req then stays high until a cycle in which rd_rdy is high. While a fetch is pending, further start pulses cause no new request.
- R2: done is high for exactly one cycle: the cycle that follows the clock edge at which rd_req and rd_rdy were both high. All result outputs carry the new values in that same cycle.
- R3: ext_id equals rd_data[7:0] and serial_id equals rd_data[15:8] of the fetched word.
- R4: The selector is rd_data[31:16]. Its form byte is rd_data[23:16]. For each i from 0 to 3, form bit i must equal form bit 7-i; if any pair differs, sel_index is 0xFFFF.
- R5: Among form bits 0..3, a single zero at position p gives a base of 16*p. No zero gives a base of 0. Two or more zeros make sel_index 0xFFFF.
- R6: The index byte is rd_data[31:24]. If its low nibble XOR its high nibble is not 0xF, sel_index is 0xFFFF.
- R7: For a valid selector, sel_index equals the base plus the low nibble of the index byte.
- R8: sel_index 0 gives margin 0x08000100 and sel_index 1 gives margin 0x0C000180, in both cases with secure_en high. Any other sel_index gives margin 0 and secure_en low.
- R9: An unprogrammed selector (0xFFFF) gives sel_index 0xFFFF, margin 0 and secure_en low.
- R10: Result outputs do not change between done pulses. They keep their values until the next completed fetch.
- R11: While rst is high, done, rd_req, secure_en, margin, ext_id and serial_id are 0, and sel_index is 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one record fetch and decode |
| rd_req | output | 1 | Read request to the OTP port |
| rd_addr | output | ADDR_W | Byte address of the requested aligned word |
| rd_rdy | input | 1 | Read data valid |
| rd_data | input | 32 | Returned word; byte 0 in bits 7:0 |
| done | output | 1 | One-cycle completion pulse |
| sel_index | output | 16 | Decoded selector index, 0xFFFF when invalid |
| margin | output | 32 | Margin constant for an accepted index |
| secure_en | output | 1 | Secure boot selected |
| ext_id | output | 8 | External identifier byte |
| serial_id | output | 8 | Serial identifier byte |

## Verification
The bench builds the block with its default parameters. The record then sits in one fixed word and the selection table holds two entries, so that every form byte and every index byte can be swept. All 256 form bytes are paired with several valid index bytes, and all 256 index bytes are paired with each legal form byte plus some illegal ones. Each result is compared with an index computed arithmetically from the rules. Read latencies of zero to three cycles and start pulses that arrive mid-fetch cover the handshake, and each run also checks that the outputs hold after done.

// File: rtl/secsel_pkg.sv
package secsel_pkg;
  typedef enum logic {FS_IDLE, FS_WAIT} fetch_st_t;
  localparam int SEL_W = 16;
  localparam logic [SEL_W-1:0] INVALID_IDX = 16'hFFFF;
endpackage

// File: rtl/secsel_fetch.sv
module secsel_fetch
  import secsel_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REC_ADDR = 16'h1580
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_rdy,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cap
);
  fetch_st_t st;

  always_ff @(posedge clk) begin
    if (rst) st <= FS_IDLE;
    else begin
      case (st)
        FS_IDLE: if (start) st <= FS_WAIT;
        FS_WAIT: if (rd_rdy) st <= FS_IDLE;
        default: st <= FS_IDLE;
      endcase
    end
  end

  assign rd_req  = (st == FS_WAIT);
  assign rd_addr = REC_ADDR;
  assign cap     = rd_req && rd_rdy;

  assert_req_addr_R1: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> rd_addr == REC_ADDR);
  assert_req_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_rdy) |=> rd_req);
endmodule

// File: rtl/secsel_check.sv
module secsel_check
  import secsel_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output logic [SEL_W-1:0] idx
);
  localparam int HALF = 4;
  logic [7:0] form, ib;
  logic       mirror_ok, nib_ok;
  logic [2:0] zcnt;
  logic [7:0] base;

  always_comb begin
    form = sel[7:0];
    ib   = sel[15:8];
    mirror_ok = 1'b1;
    zcnt = '0;
    base = '0;
    for (int i = 0; i < HALF; i++) begin
      if (form[i] != form[7-i]) mirror_ok = 1'b0;
      if (!form[i]) begin
        zcnt = zcnt + 3'd1;
        base = 8'(i * 16);
      end
    end
    nib_ok = ((ib[3:0] ^ ib[7:4]) == 4'hF);
    if (mirror_ok && zcnt <= 3'd1 && nib_ok)
      idx = {8'h00, base + {4'h0, ib[3:0]}};
    else
      idx = INVALID_IDX;
  end
endmodule

// File: rtl/secsel_margin.sv
module secsel_margin
  import secsel_pkg::*;
#(
  parameter int MW = 32,
  parameter int NUM_MARGIN = 2,
  parameter logic [NUM_MARGIN*MW-1:0] MARGIN_TBL = {32'h0C000180, 32'h08000100}
) (
  input  logic [SEL_W-1:0] idx,
  output logic [MW-1:0]    margin,
  output logic             hit
);
  logic [NUM_MARGIN-1:0] hv;
  logic [MW-1:0]         mv [NUM_MARGIN];

  for (genvar k = 0; k < NUM_MARGIN; k++) begin : g_ent
    assign hv[k] = (idx == SEL_W'(k));
    assign mv[k] = hv[k] ? MARGIN_TBL[k*MW +: MW] : '0;
  end

  always_comb begin
    margin = '0;
    for (int k = 0; k < NUM_MARGIN; k++) margin = margin | mv[k];
    hit = |hv;
  end
endmodule

// File: rtl/secboot_sel_decoder.sv
module secboot_sel_decoder
  import secsel_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REC_ADDR = 16'h1580,
  parameter int MW = 32,
  parameter int NUM_MARGIN = 2,
  parameter logic [NUM_MARGIN*MW-1:0] MARGIN_TBL = {32'h0C000180, 32'h08000100}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rdy,
  input  logic [31:0]       rd_data,
  output logic              done,
  output logic [SEL_W-1:0]  sel_index,
  output logic [MW-1:0]     margin,
  output logic              secure_en,
  output logic [7:0]        ext_id,
  output logic [7:0]        serial_id
);
  logic             cap;
  logic [SEL_W-1:0] dec_idx;
  logic [MW-1:0]    dec_margin;
  logic             dec_hit;

  secsel_fetch #(.ADDR_W(ADDR_W), .REC_ADDR(REC_ADDR)) u_fetch (
    .clk(clk), .rst(rst), .start(start), .rd_rdy(rd_rdy),
    .rd_req(rd_req), .rd_addr(rd_addr), .cap(cap)
  );

  secsel_check u_check (.sel(rd_data[31:16]), .idx(dec_idx));

  secsel_margin #(.MW(MW), .NUM_MARGIN(NUM_MARGIN), .MARGIN_TBL(MARGIN_TBL)) u_margin (
    .idx(dec_idx), .margin(dec_margin), .hit(dec_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      sel_index <= INVALID_IDX;
      margin    <= '0;
      secure_en <= 1'b0;
      ext_id    <= '0;
      serial_id <= '0;
    end else begin
      done <= cap;
      if (cap) begin
        sel_index <= dec_idx;
        margin    <= dec_margin;
        secure_en <= dec_hit;
        ext_id    <= rd_data[7:0];
        serial_id <= rd_data[15:8];
      end
    end
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_after_cap_R2: assert property (@(posedge clk) disable iff (rst)
    cap |=> done);
  assert_secure_idx_R8: assert property (@(posedge clk) disable iff (rst)
    secure_en |-> (sel_index < SEL_W'(NUM_MARGIN) && margin != '0));
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !cap |=> ($stable(sel_index) && $stable(margin) && $stable(ext_id)));
  assert_nibble_R6: assert property (@(posedge clk) disable iff (rst)
    (done && sel_index != INVALID_IDX) |->
      (($past(rd_data[27:24]) ^ $past(rd_data[31:28])) == 4'hF));
endmodule

// File: tb/tb_secboot_sel_decoder.sv
module tb_secboot_sel_decoder;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0, rd_rdy = 1'b0;
  logic [31:0] rd_data = '0;
  logic rd_req, done, secure_en;
  logic [15:0] rd_addr, sel_index;
  logic [31:0] margin;
  logic [7:0] ext_id, serial_id;
  int errs = 0, checks = 0, cyc = 0;

  always #2 clk = ~clk;

  secboot_sel_decoder dut (
    .clk(clk), .rst(rst), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_rdy(rd_rdy), .rd_data(rd_data), .done(done), .sel_index(sel_index),
    .margin(margin), .secure_en(secure_en), .ext_id(ext_id), .serial_id(serial_id)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [15:0] sel);
    int f, ib, zeros, pos, lo, hi;
    f = sel[7:0]; ib = sel[15:8];
    for (int i = 0; i < 4; i++)
      if (((f >> i) & 1) != ((f >> (7 - i)) & 1)) return 16'hFFFF;
    zeros = 0; pos = 0;
    for (int i = 0; i < 4; i++)
      if (((f >> i) & 1) == 0) begin zeros++; pos = i; end
    if (zeros > 1) return 16'hFFFF;
    lo = ib % 16; hi = ib / 16;
    if (lo + hi != 15) return 16'hFFFF;
    return 16'((zeros == 1 ? pos * 16 : 0) + lo);
  endfunction

  task automatic run(input logic [15:0] sel, input logic [7:0] e, input logic [7:0] s, input int lat);
    logic [15:0] xi;
    logic [31:0] xm;
    int guard;
    xi = model(sel);
    xm = (xi == 16'd0) ? 32'h08000100 : (xi == 16'd1) ? 32'h0C000180 : 32'h0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(rd_req === 1'b1 && rd_addr === 16'h1580, "R1", {15'd0, rd_req, rd_addr}, {16'd1, 16'h1580});
    guard = 0;
    while (!rd_req && guard < 10) begin @(negedge clk); guard++; end
    for (int w = 0; w < lat; w++) begin
      if (w == 0) start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(rd_req === 1'b1 && done === 1'b0, "R1", {30'd0, rd_req, done}, 32'd2);
    end
    rd_rdy = 1'b1; rd_data = {sel, s, e};
    @(negedge clk); rd_rdy = 1'b0; rd_data = ~rd_data;
    chk(done === 1'b1 && rd_req === 1'b0, "R2", {30'd0, done, rd_req}, 32'd2);
    chk(sel_index === xi, (sel == 16'hFFFF) ? "R9" : "R4 R5 R6 R7", {16'd0, sel_index}, {16'd0, xi});
    chk(margin === xm && secure_en === (xm != 0), "R8", margin, xm);
    chk(ext_id === e && serial_id === s, "R3", {16'd0, serial_id, ext_id}, {16'd0, s, e});
    @(negedge clk);
    @(negedge clk);
    chk(done === 1'b0 && rd_req === 1'b0 && sel_index === xi && margin === xm && ext_id === e,
        "R10", {16'd0, sel_index}, {16'd0, xi});
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk(done === 0 && rd_req === 0 && secure_en === 0 && margin === 0 && sel_index === 16'hFFFF
        && ext_id === 0 && serial_id === 0, "R11", {16'd0, sel_index}, 32'h0000FFFF);
    rst = 1'b0;
    run(16'hFFFF, 8'h12, 8'h34, 0);
    run(16'hF0FF, 8'hA5, 8'h5A, 1);
    run(16'hE17E, 8'h01, 8'h02, 2);
    run(16'hE1FE, 8'h03, 8'h04, 3);
    for (int f = 0; f < 256; f++) begin
      run({8'hF0, 8'(f)}, 8'(f), 8'(~f), f % 4);
      run({8'hE1, 8'(f)}, 8'(f + 1), 8'(f), (f + 1) % 4);
      run({8'h3C, 8'(f)}, 8'(f * 3), 8'(f + 7), (f + 2) % 4);
    end
    for (int b = 0; b < 256; b++) begin
      run({8'(b), 8'hFF}, 8'(b), 8'h11, b % 4);
      run({8'(b), 8'h7E}, 8'h22, 8'(b), (b + 1) % 4);
      run({8'(b), 8'hBD}, 8'(b ^ 8'h55), 8'h33, (b + 2) % 4);
      run({8'(b), 8'hDB}, 8'h44, 8'h55, (b + 3) % 4);
      run({8'(b), 8'hE7}, 8'h66, 8'(b), b % 4);
      run({8'(b), 8'h00}, 8'h77, 8'h88, 1);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule